// File: doc/BRIEF.md
# Channel-Masked Stream Unpacker

The unpacker takes a packed stream of samples, one beat of `NUM_CH × SPC` samples per valid/ready handshake, and hands the samples out over parallel channel lanes. Only the lanes set in a channel mask receive samples. Each output word has the same slot layout as an input beat. Every enabled lane receives `SPC` consecutive samples per word, and the slots of lanes that are switched off are driven to zero.

When fewer lanes are enabled, one input beat feeds more than one output word. Samples that are left over after a word has been built stay buffered and open the next word, so the stream never breaks at a beat boundary. The output side behaves like a FIFO read port. A read request that arrives while enough samples are buffered produces a registered word. The `outValid` flag is raised on the clock after the request. The input is throttled so the buffer never holds more than the next word needs plus one beat.

Top module: `unpack_stream`

## Requirements
- R1: Output slot `c*SPC + h` (each slot `SW` bits wide, slot 0 in the least significant bits) holds lane `c`'s sample number `h` of that word.
- R2: Within a word, samples are handed out in stream order with the sample number `h` as the outer loop and ascending lane number as the inner loop, skipping disabled lanes. Input slot 0 is the oldest sample of a beat.
- R3: Samples left over after a word is built open the next word in order, across beat boundaries, with no sample lost or repeated.
- R4: A beat is taken only in a cycle where `inValid` and `inReady` are both high. `inData` is ignored in every other cycle.
- R5: `inReady` is high exactly when reset is low, the mask is non-zero, and the samples still buffered after this cycle's read (if any) are fewer than one word's worth (`popcount(mask)*SPC`).
- R6: A word is produced only in a cycle where the read request (any `rdEn` bit of an enabled lane) is high and at least one word's worth of samples is buffered. `outValid` is high on the next cycle only. `outData` changes only on such a cycle.
- R7: A synchronous reset (`rst` high) drops every buffered sample and clears `outValid` and `outData`. After reset, the first word starts with slot 0 of the next accepted beat.
- R8: Every non-zero mask, from one lane up to all lanes, follows R1 to R3.
- R9: With an all-zero mask, `inReady` and `outValid` stay low.
- R10: With all lanes enabled and both `inValid` and the read request held high, a word comes out on every cycle from the second cycle after reset onward.
- R11: Slots of disabled lanes are driven to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high. The mask may change only while it is held |
| chanMask | input | NUM_CH | Lane enable mask |
| rdEn | input | NUM_CH | Per-lane read enables. Any bit of an enabled lane requests a word |
| inValid | input | 1 | Input beat valid |
| inReady | output | 1 | Input beat accepted when high together with inValid |
| inData | input | NUM_CH*SPC*SW | Input beat, slot 0 oldest |
| outValid | output | 1 | Registered: a new word is on outData |
| outData | output | NUM_CH*SPC*SW | Output word, slot c*SPC+h per lane and sample |

## Verification
`inReady` is combinational, so the bench compares it with the reference queue 1 ns after it drives each cycle's inputs, before the clock edge. A word requested in cycle n appears on `outValid`/`outData` after the edge that closes cycle n. The bench samples those outputs 1 ns after that edge and compares them with the word the queue model popped in the same cycle. Every clock is compared this way under all fifteen masks, under an idle mask, under full-rate streaming and across a reset in mid-stream.

// File: rtl/unpack_pkg.sv
package unpack_pkg;

  // Strobes from the control to the datapath, one cycle's decisions.
  typedef struct packed {
    logic accept;  // an input beat is appended this cycle
    logic emit;    // one output word is taken from the buffer front
  } unpack_strobe_t;

endpackage

// File: rtl/unpack_lane_map.sv
module unpack_lane_map #(
  parameter int NUM_CH = 4,
  parameter int EN_W   = $clog2(NUM_CH + 1)
) (
  input  logic [NUM_CH-1:0]           chanMask,
  output logic [NUM_CH-1:0][EN_W-1:0] lowerCount,
  output logic [EN_W-1:0]             enabledCount
);

  // lowerCount[c]: number of enabled lanes with a lower index than c.
  for (genvar c = 0; c < NUM_CH; c++) begin : gLane
    logic [EN_W-1:0] acc;
    always_comb begin
      acc = '0;
      for (int k = 0; k < c; k++) begin
        acc = acc + EN_W'(chanMask[k]);
      end
    end
    assign lowerCount[c] = acc;
  end

  assign enabledCount = lowerCount[NUM_CH-1] + EN_W'(chanMask[NUM_CH-1]);

endmodule

// File: rtl/unpack_ctrl.sv
module unpack_ctrl
  import unpack_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int SPC    = 2,
  parameter int EN_W   = $clog2(NUM_CH + 1),
  parameter int DEPTH  = 2 * NUM_CH * SPC,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [EN_W-1:0]  enabledCount,
  input  logic             rdReq,
  input  logic             inValid,
  output logic             inReady,
  output unpack_strobe_t   strobe,
  output logic [CNT_W-1:0] fill,
  output logic [CNT_W-1:0] wordSamples
);

  localparam int BEAT = NUM_CH * SPC;

  logic [CNT_W-1:0] leftOver;
  logic [CNT_W-1:0] fillNext;
  logic             emitNow;
  logic             acceptNow;

  assign wordSamples = CNT_W'(int'(enabledCount) * SPC);

  always_comb begin
    emitNow   = !rst && rdReq && (wordSamples != '0) && (fill >= wordSamples);
    leftOver  = fill - (emitNow ? wordSamples : '0);
    inReady   = !rst && (wordSamples != '0) && (leftOver < wordSamples);
    acceptNow = inValid && inReady;
    fillNext  = leftOver + (acceptNow ? CNT_W'(BEAT) : '0);
  end

  assign strobe.accept = acceptNow;
  assign strobe.emit   = emitNow;

  always_ff @(posedge clk) begin
    if (rst) fill <= '0;
    else     fill <= fillNext;
  end

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
    fill <= CNT_W'(DEPTH)); // R5

  AST_TAKE_ONLY_WHEN_SHORT: assert property (@(posedge clk) disable iff (rst)
    strobe.accept |-> (int'(fill) < 2 * int'(wordSamples))); // R5

  AST_EMPTY_MASK_IDLE: assert property (@(posedge clk) disable iff (rst)
    (enabledCount == '0) |-> (!inReady && !strobe.emit)); // R9

endmodule

// File: rtl/unpack_datapath.sv
module unpack_datapath
  import unpack_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int SPC    = 2,
  parameter int SW     = 8,
  parameter int EN_W   = $clog2(NUM_CH + 1),
  parameter int DEPTH  = 2 * NUM_CH * SPC,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  unpack_strobe_t                strobe,
  input  logic [CNT_W-1:0]              fill,
  input  logic [CNT_W-1:0]              wordSamples,
  input  logic [EN_W-1:0]               enabledCount,
  input  logic [NUM_CH-1:0][EN_W-1:0]   lowerCount,
  input  logic [NUM_CH-1:0]             chanMask,
  input  logic [NUM_CH*SPC*SW-1:0]      inData,
  output logic [NUM_CH*SPC*SW-1:0]      outData
);

  localparam int BEAT  = NUM_CH * SPC;
  localparam int IDX_W = $clog2(DEPTH);

  logic [SW-1:0] store     [DEPTH];
  logic [SW-1:0] storeNext [DEPTH];
  logic [BEAT*SW-1:0] wordNext;

  // Buffer front is the oldest sample; a read drops wordSamples entries from
  // the front and an accepted beat lands just behind what remains.
  always_comb begin
    int shiftAmt;
    shiftAmt = strobe.emit ? int'(wordSamples) : 0;
    for (int i = 0; i < DEPTH; i++) begin
      int src;
      int off;
      src = i + shiftAmt;
      off = src - int'(fill);
      if (src < int'(fill)) begin
        storeNext[i] = store[src[IDX_W-1:0]];
      end else if (strobe.accept && off >= 0 && off < BEAT) begin
        storeNext[i] = inData[off*SW +: SW];
      end else begin
        storeNext[i] = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (rst) store[i] <= '0;
      else     store[i] <= storeNext[i];
    end
  end

  // Sample number h of lane c is stream entry h*enabled + (enabled lanes below c).
  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      for (int h = 0; h < SPC; h++) begin
        int rank;
        rank = h * int'(enabledCount) + int'(lowerCount[c]);
        if (chanMask[c]) wordNext[(c*SPC+h)*SW +: SW] = store[rank[IDX_W-1:0]];
        else             wordNext[(c*SPC+h)*SW +: SW] = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              outData <= '0;
    else if (strobe.emit) outData <= wordNext;
  end

  AST_WORD_HELD: assert property (@(posedge clk) disable iff (rst)
    !strobe.emit |=> $stable(outData)); // R6

  for (genvar c = 0; c < NUM_CH; c++) begin : gIdleSlot
    AST_IDLE_SLOT_ZERO: assert property (@(posedge clk) disable iff (rst)
      !chanMask[c] |-> (outData[c*SPC*SW +: SPC*SW] == '0)); // R11
  end

endmodule

// File: rtl/unpack_stream.sv
module unpack_stream
  import unpack_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int SPC    = 2,
  parameter int SW     = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_CH-1:0]        chanMask,
  input  logic [NUM_CH-1:0]        rdEn,
  input  logic                     inValid,
  output logic                     inReady,
  input  logic [NUM_CH*SPC*SW-1:0] inData,
  output logic                     outValid,
  output logic [NUM_CH*SPC*SW-1:0] outData
);

  localparam int EN_W  = $clog2(NUM_CH + 1);
  localparam int DEPTH = 2 * NUM_CH * SPC;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [NUM_CH-1:0][EN_W-1:0] lowerCount;
  logic [EN_W-1:0]             enabledCount;
  logic [CNT_W-1:0]            fill;
  logic [CNT_W-1:0]            wordSamples;
  logic                        rdReq;
  unpack_strobe_t              strobe;

  assign rdReq = |(rdEn & chanMask);

  unpack_lane_map #(.NUM_CH(NUM_CH), .EN_W(EN_W)) uMap (
    .chanMask     (chanMask),
    .lowerCount   (lowerCount),
    .enabledCount (enabledCount)
  );

  unpack_ctrl #(
    .NUM_CH(NUM_CH), .SPC(SPC), .EN_W(EN_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
  ) uCtrl (
    .clk          (clk),
    .rst          (rst),
    .enabledCount (enabledCount),
    .rdReq        (rdReq),
    .inValid      (inValid),
    .inReady      (inReady),
    .strobe       (strobe),
    .fill         (fill),
    .wordSamples  (wordSamples)
  );

  unpack_datapath #(
    .NUM_CH(NUM_CH), .SPC(SPC), .SW(SW), .EN_W(EN_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
  ) uData (
    .clk          (clk),
    .rst          (rst),
    .strobe       (strobe),
    .fill         (fill),
    .wordSamples  (wordSamples),
    .enabledCount (enabledCount),
    .lowerCount   (lowerCount),
    .chanMask     (chanMask),
    .inData       (inData),
    .outData      (outData)
  );

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= strobe.emit;
  end

  AST_VALID_ANSWERS_READ: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(rdReq)); // R6

  AST_MASK_ZERO_SILENT: assert property (@(posedge clk) disable iff (rst)
    (chanMask == '0) |-> (!inReady && !outValid)); // R9

endmodule

// File: tb/tb_unpack_stream.sv
`timescale 1ns/1ps
module tb_unpack_stream;

  localparam int NUM_CH = 4;
  localparam int SPC    = 2;
  localparam int SW     = 8;
  localparam int BEAT   = NUM_CH * SPC;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [NUM_CH-1:0]    chanMask = 4'b0101;
  logic [NUM_CH-1:0]    rdEn = '0;
  logic                 inValid = 1'b0;
  logic                 inReady;
  logic [BEAT*SW-1:0]   inData = '0;
  logic                 outValid;
  logic [BEAT*SW-1:0]   outData;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference model state
  int          q[$];
  int          seq = 0;
  logic [BEAT*SW-1:0] expData = '0;
  bit          expValid = 0;
  int          validSeen = 0;

  always #2 clk = ~clk;

  unpack_stream #(.NUM_CH(NUM_CH), .SPC(SPC), .SW(SW)) dut (
    .clk(clk), .rst(rst), .chanMask(chanMask), .rdEn(rdEn),
    .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outData(outData)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int popCnt(input logic [NUM_CH-1:0] m);
    int n = 0;
    for (int k = 0; k < NUM_CH; k++) n += int'(m[k]);
    return n;
  endfunction

  // One clock: drive at negedge, check ready before the edge, check outputs after it.
  task automatic cycle(input bit v, input logic [NUM_CH-1:0] rdVec);
    int ws;
    bit rq, mRead, mReady, mTake;
    int left;
    @(negedge clk);
    inValid = v;
    rdEn    = rdVec;
    for (int s = 0; s < BEAT; s++)
      inData[s*SW +: SW] = v ? SW'(seq + s) : 8'hA5;
    #1;
    ws     = popCnt(chanMask) * SPC;
    rq     = |(rdVec & chanMask);
    mRead  = !rst && rq && ws > 0 && q.size() >= ws;
    left   = q.size() - (mRead ? ws : 0);
    mReady = !rst && ws > 0 && left < ws;
    mTake  = v && mReady;
    chk(inReady == mReady, "R5", "inReady", longint'(inReady), longint'(mReady));
    if (chanMask == '0) chk(!inReady, "R9", "inReady with empty mask", longint'(inReady), 0);
    @(posedge clk);
    #1;
    if (rst) begin
      q.delete();
      expValid = 0;
      expData  = '0;
    end else begin
      if (mRead) begin
        expData = '0;
        for (int h = 0; h < SPC; h++)
          for (int c = 0; c < NUM_CH; c++)
            if (chanMask[c]) expData[(c*SPC+h)*SW +: SW] = SW'(q.pop_front());
      end
      expValid = mRead;
      if (mTake) begin
        for (int s = 0; s < BEAT; s++) q.push_back(seq + s);
        seq += BEAT;
      end
    end
    if (outValid) validSeen++;
    chk(outValid == expValid, "R6", "outValid", longint'(outValid), longint'(expValid));
    if (rst) chk(outData == '0, "R7", "outData in reset", longint'(outData), 0);
    if (expValid && !rst)
      for (int c = 0; c < NUM_CH; c++) begin
        if (chanMask[c])
          chk(outData[c*SPC*SW +: SPC*SW] == expData[c*SPC*SW +: SPC*SW], "R1 R2 R3",
              "lane word", longint'(outData[c*SPC*SW +: SPC*SW]),
              longint'(expData[c*SPC*SW +: SPC*SW]));
        else
          chk(outData[c*SPC*SW +: SPC*SW] == '0, "R11", "disabled lane slots",
              longint'(outData[c*SPC*SW +: SPC*SW]), 0);
      end
  endtask

  task automatic doReset(input logic [NUM_CH-1:0] m);
    rst = 1'b1;
    chanMask = m;
    cycle(1'b1, '1);
    cycle(1'b0, '0);
    rst = 1'b0;
  endtask

  initial begin
    // Reset state (R7)
    rst = 1'b1;
    cycle(1'b0, '0);
    cycle(1'b1, '1);
    chk(outValid == 1'b0 && inReady == 1'b0, "R7", "reset state",
        longint'({outValid, inReady}), 0);

    // Every non-zero mask with irregular traffic (R8, R4, R3)
    for (int m = 1; m < (1 << NUM_CH); m++) begin
      doReset(NUM_CH'(m));
      for (int n = 0; n < 40; n++) begin
        logic [NUM_CH-1:0] rv;
        bit v;
        v  = ($urandom % 4) != 0;
        rv = (($urandom % 3) != 0) ? '1 : '0;
        if (($urandom % 7) == 0) rv = ~chanMask;  // request only on disabled lanes: no read (R6)
        cycle(v, rv);
      end
      chk(1'b1, "R8", "mask sweep step", m, m);
    end

    // Full rate, all lanes (R10)
    doReset('1);
    validSeen = 0;
    cycle(1'b1, '1);
    cycle(1'b1, '1);
    validSeen = 0;
    for (int n = 0; n < 28; n++) cycle(1'b1, '1);
    chk(validSeen == 28, "R10", "words at full rate", validSeen, 28);

    // Empty mask: nothing taken, nothing produced (R9)
    doReset('0);
    validSeen = 0;
    for (int n = 0; n < 10; n++) cycle(1'b1, '1);
    chk(validSeen == 0, "R9", "words with empty mask", validSeen, 0);

    // Mid-stream reset drops buffered samples (R7)
    doReset(4'b0110);
    for (int n = 0; n < 4; n++) cycle(1'b1, '0);
    cycle(1'b0, '1);
    rst = 1'b1;
    cycle(1'b1, '1);
    rst = 1'b0;
    begin
      int first;
      first = seq;
      cycle(1'b1, '0);
      cycle(1'b0, '1);
      chk(outValid && outData[1*SPC*SW +: SW] == SW'(first), "R7",
          "first word after reset", longint'(outData[1*SPC*SW +: SW]), longint'(SW'(first)));
    end
    for (int n = 0; n < 20; n++) cycle(($urandom % 2) == 0, '1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule